// File: doc/BRIEF.md
# PRBS Receive Checker with Link Hysteresis

This block sits behind a deserialiser. It judges whether a stream of received parallel words follows a known test pattern. For every word it predicts the bits it should have seen, using the selected pattern rule, and compares them with what arrived. It reports whether that word was errored, and it keeps a flag that says whether the channel is locked to the pattern.

The flag uses hysteresis: a run of clean words is needed to raise it and a run of errored words is needed to drop it. Two running totals count the words received and the bit errors found. A single pulse clears both totals.

The prediction comes from a window of the most recent 31 bits of the stream. While the channel is unlinked, that window is refilled from the received bits, so the checker aligns itself to any phase of the incoming pattern without a seed. Once linked, the window is refilled from its own predictions. A burst of line errors is then counted bit for bit and does not disturb the reference. Word alignment on the serial line is taken as given. The checker aligns only its own pattern state.

Top module: `prbs_link_checker`

## Requirements
- R1: `pat_sel` picks the rule bit n = b[n-p] XOR b[n-q], or bit n = NOT b[n-p] for the clock patterns, with bit 0 of each word the earliest in time. The codes are: 0 gives p=6,q=7 (PRBS-7); 1 gives 14,15 (PRBS-15); 2 gives 18,23 (PRBS-23); 3 gives 28,31 (PRBS-31); 4 gives NOT b[n-1] (2x clock, 1010...); 5 gives NOT b[n-10] (10x clock, ten ones then ten zeros). Codes 6 and 7 act as code 0.
- R2: `word_err` updates at the clock edge that takes a valid word, to 1 if any bit differs from the prediction and to 0 otherwise. It holds its value while `rx_valid` is low.
- R3: `link` rises at the edge that takes the fifth consecutive clean valid word.
- R4: `link` falls at the edge that takes the fifth consecutive errored valid word.
- R5: A clean word zeroes the errored-word run and an errored word zeroes the clean-word run. Cycles without `rx_valid` leave both runs unchanged.
- R6: `word_count` grows by one for each valid word and is unchanged on cycles without one.
- R7: `err_count` grows by the number of mismatched bits in each valid word.
- R8: A `cnt_clr` cycle zeroes both counters at the next edge, even when a valid word arrives in the same cycle. It has no effect on `link`.
- R9: Both counters stop at all ones instead of wrapping.
- R10: A change of `pat_sel` drops `link` at the next edge and zeroes both runs.
- R11: While unlinked, the prediction window is refilled from the received bits, so the second clean word follows a change of phase when the rule spans no more than one word, and the third when it spans up to two words. While linked, the window is refilled from the prediction, so a corrupted word does not cause errors in the words after it.
- R12: During reset, `link` and `word_err` are 0 and both counters are 0. Reset is applied at once and released after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_data | input | DATA_W | Received word, bit 0 earliest on the line |
| rx_valid | input | 1 | Qualifies `rx_data` for this cycle |
| pat_sel | input | 3 | Receive pattern code (R1) |
| cnt_clr | input | 1 | Zeroes both counters |
| link | output | 1 | Channel locked to the pattern |
| word_err | output | 1 | Last valid word contained at least one bit error |
| word_count | output | WCNT_W | Saturating count of valid words |
| err_count | output | ECNT_W | Saturating count of mismatched bits |

## Verification
The bench interleaves clean and errored words so that neither run ever reaches five on its own before it is broken. A design that failed to reset the opposite run would then change `link` early. Bits are corrupted on purpose while the channel is linked, and the next word must be clean. A checker that kept reloading from the line would smear one bad word into several and count far more errors.

Each pattern code is locked after a change of phase. Lock must arrive on the second word for rules that span at most one word and on the third for the longer ones. A wrong tap or a swapped code never locks. The bench also toggles `pat_sel` in the middle of a clean run, fires a clear in the same cycle as a word, and drives a narrow-counter instance past full scale. These catch a run that survives the select change, a clear that loses to the increment, and a counter that wraps.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  // Length of the prediction window: longest rule span
  localparam int HIST_W = 31;

  typedef enum logic [2:0] {
    PAT_P7    = 3'd0,
    PAT_P15   = 3'd1,
    PAT_P23   = 3'd2,
    PAT_P31   = 3'd3,
    PAT_CLK2  = 3'd4,
    PAT_CLK10 = 3'd5
  } pat_e;

  // Recurrence: bit n = seq[n-near] ^ (use_far ? seq[n-far] : 0) ^ invert
  typedef struct packed {
    logic [4:0] near_tap;
    logic [4:0] far_tap;
    logic       use_far;
    logic       invert;
  } rule_t;

  function automatic rule_t rule_of(input logic [2:0] code);
    rule_t r;
    r = '{near_tap: 5'd6, far_tap: 5'd7, use_far: 1'b1, invert: 1'b0};
    case (pat_e'(code))
      PAT_P15:   r = '{near_tap: 5'd14, far_tap: 5'd15, use_far: 1'b1, invert: 1'b0};
      PAT_P23:   r = '{near_tap: 5'd18, far_tap: 5'd23, use_far: 1'b1, invert: 1'b0};
      PAT_P31:   r = '{near_tap: 5'd28, far_tap: 5'd31, use_far: 1'b1, invert: 1'b0};
      PAT_CLK2:  r = '{near_tap: 5'd1,  far_tap: 5'd1,  use_far: 1'b0, invert: 1'b1};
      PAT_CLK10: r = '{near_tap: 5'd10, far_tap: 5'd10, use_far: 1'b0, invert: 1'b1};
      default:   r = '{near_tap: 5'd6,  far_tap: 5'd7,  use_far: 1'b1, invert: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/prbs_chk_predict.sv
module prbs_chk_predict
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel_i,
  input  logic              adv_i,
  input  logic              linked_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic [DATA_W-1:0] exp_o
);

  localparam int SEQ_W = HIST_W + DATA_W;

  // hist_q[0] is the oldest bit, hist_q[HIST_W-1] the newest
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;
  logic [SEQ_W-1:0]  seq;
  logic [SEQ_W-1:0]  refill;
  logic [DATA_W-1:0] src;
  rule_t             rule;
  logic              nb;
  int                pos;

  // Next-state: extend the window one bit at a time by the selected rule
  always_comb begin
    rule = rule_of(sel_i);
    seq  = {{DATA_W{1'b0}}, hist_q};
    nb   = 1'b0;
    pos  = 0;
    for (int i = 0; i < DATA_W; i++) begin
      pos = HIST_W + i;
      nb  = seq[pos - int'(rule.near_tap)];
      if (rule.use_far) begin
        nb = nb ^ seq[pos - int'(rule.far_tap)];
      end
      if (rule.invert) begin
        nb = ~nb;
      end
      seq[pos] = nb;
    end
    exp_o = seq[SEQ_W-1:HIST_W];
  end

  // Window refill source: line while hunting, own prediction once locked
  always_comb begin
    src    = linked_i ? exp_o : rx_i;
    refill = {src, hist_q};
    hist_d = refill[SEQ_W-1 -: HIST_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (adv_i) begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/prbs_chk_link.sv
module prbs_chk_link #(
  parameter int RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       ok_i,
  input  logic       bad_i,
  output logic       link_o
);

  localparam int            RW    = $clog2(RUN + 1);
  localparam logic [RW-1:0] RUN_V = RW'(RUN);

  logic [2:0]    sel_q;
  logic [RW-1:0] clean_q, clean_d;
  logic [RW-1:0] bad_q, bad_d;
  logic          link_q, link_d;
  logic          sel_chg;

  always_comb begin
    sel_chg = (sel_i != sel_q);
    clean_d = clean_q;
    bad_d   = bad_q;
    link_d  = link_q;
    if (sel_chg) begin
      clean_d = '0;
      bad_d   = '0;
      link_d  = 1'b0;
    end else if (ok_i) begin
      bad_d   = '0;
      clean_d = (clean_q == RUN_V) ? RUN_V : clean_q + 1'b1;
      if (clean_d == RUN_V) begin
        link_d = 1'b1;
      end
    end else if (bad_i) begin
      clean_d = '0;
      bad_d   = (bad_q == RUN_V) ? RUN_V : bad_q + 1'b1;
      if (bad_d == RUN_V) begin
        link_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      clean_q <= '0;
      bad_q   <= '0;
      link_q  <= 1'b0;
    end else begin
      sel_q   <= sel_i;
      clean_q <= clean_d;
      bad_q   <= bad_d;
      link_q  <= link_d;
    end
  end

  assign link_o = link_q;

  AST_LINK_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_o) |-> $past(ok_i)) else $error("link rose without a clean word"); // R3
  AST_LINK_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_o) |-> $past(bad_i || (sel_i != sel_q))) else $error("link fell without cause"); // R4
  AST_RUNS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !((clean_q != '0) && (bad_q != '0))) else $error("both runs active"); // R5
  AST_SEL_DROPS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i != sel_q) |=> !link_o) else $error("link kept over select change"); // R10

endmodule

// File: rtl/prbs_chk_accum.sv
module prbs_chk_accum #(
  parameter int CW    = 48,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CW-1:0]    cnt_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + {{(CW + 1 - INC_W){1'b0}}, inc_i};
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)) else $error("counter not cleared"); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q >= $past(cnt_q))) else $error("counter wrapped"); // R9
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q)) else $error("counter moved while idle"); // R6

endmodule

// File: rtl/prbs_link_checker.sv
module prbs_link_checker
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int WCNT_W   = 48,
  parameter int ECNT_W   = 32,
  parameter int LINK_RUN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic [2:0]        pat_sel,
  input  logic              cnt_clr,
  output logic              link,
  output logic              word_err,
  output logic [WCNT_W-1:0] word_count,
  output logic [ECNT_W-1:0] err_count
);

  localparam int POP_W   = $clog2(DATA_W + 1);
  localparam int SYNC_ST = 2;

  // Reset: asserted asynchronously, released after SYNC_ST edges
  logic [SYNC_ST-1:0] rst_pipe;
  logic               rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_ST-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[SYNC_ST-1];

  logic [DATA_W-1:0] exp_word;
  logic [DATA_W-1:0] mism;
  logic [POP_W-1:0]  pop;
  logic              word_bad;
  logic              ok_v, bad_v;
  logic              flag_q, flag_d;

  prbs_chk_predict #(.DATA_W(DATA_W)) u_predict (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_i    (pat_sel),
    .adv_i    (rx_valid),
    .linked_i (link),
    .rx_i     (rx_data),
    .exp_o    (exp_word)
  );

  always_comb begin
    mism = rx_data ^ exp_word;
    pop  = '0;
    for (int i = 0; i < DATA_W; i++) begin
      pop = pop + POP_W'(mism[i]);
    end
    word_bad = |mism;
    ok_v     = rx_valid & ~word_bad;
    bad_v    = rx_valid & word_bad;
    flag_d   = rx_valid ? word_bad : flag_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end
  assign word_err = flag_q;

  prbs_chk_link #(.RUN(LINK_RUN)) u_link (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sel_i  (pat_sel),
    .ok_i   (ok_v),
    .bad_i  (bad_v),
    .link_o (link)
  );

  // Two saturating totals share one accumulator design
  localparam int NCNT = 2;
  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    if (g == 0) begin : g_words
      prbs_chk_accum #(.CW(WCNT_W), .INC_W(1)) u_acc (
        .clk   (clk),
        .rst_n (rst_int_n),
        .en_i  (rx_valid),
        .clr_i (cnt_clr),
        .inc_i (1'b1),
        .cnt_o (word_count)
      );
    end else begin : g_errs
      prbs_chk_accum #(.CW(ECNT_W), .INC_W(POP_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_int_n),
        .en_i  (rx_valid),
        .clr_i (cnt_clr),
        .inc_i (pop),
        .cnt_o (err_count)
      );
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rx_valid |=> $stable(word_err)) else $error("flag moved without a word"); // R2
  AST_LINKED_CLEAN_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(link) |-> !word_err) else $error("linked on an errored word"); // R3

endmodule

// File: tb/prbs_link_checker_tb.sv
module prbs_link_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 20;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst_n;
  logic [DW-1:0] rx_data;
  logic          rx_valid;
  logic [2:0]    pat_sel;
  logic          cnt_clr;
  logic          link, word_err;
  logic [47:0]   word_count;
  logic [31:0]   err_count;

  logic [DW-1:0] s_rx;
  logic          s_valid;
  logic          s_link, s_err;
  logic [3:0]    s_words;
  logic [5:0]    s_errs;

  prbs_link_checker u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .pat_sel(pat_sel), .cnt_clr(cnt_clr), .link(link), .word_err(word_err),
    .word_count(word_count), .err_count(err_count)
  );

  prbs_link_checker #(.DATA_W(DW), .WCNT_W(4), .ECNT_W(6), .LINK_RUN(5)) u_dut_sat (
    .clk(clk), .rst_n(rst_n), .rx_data(s_rx), .rx_valid(s_valid),
    .pat_sel(3'd4), .cnt_clr(1'b0), .link(s_link), .word_err(s_err),
    .word_count(s_words), .err_count(s_errs)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  int          cur_sel = 0;
  logic [63:0] bh;
  bit          finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // Reference stream: bh[k] is the bit k+1 positions back
  task automatic gen(input int s, output logic [DW-1:0] w);
    logic nb;
    for (int i = 0; i < DW; i++) begin
      case (s)
        1:       nb = bh[14] ^ bh[13];
        2:       nb = bh[22] ^ bh[17];
        3:       nb = bh[30] ^ bh[27];
        4:       nb = ~bh[0];
        5:       nb = ~bh[9];
        default: nb = bh[6] ^ bh[5];
      endcase
      bh   = {bh[62:0], nb};
      w[i] = nb;
    end
  endtask

  task automatic send(input logic [DW-1:0] w);
    rx_data  = w;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_gen(input logic [DW-1:0] flip, output logic [DW-1:0] sent);
    logic [DW-1:0] w;
    gen(cur_sel, w);
    sent = w ^ flip;
    send(sent);
  endtask

  task automatic set_sel(input int s);
    pat_sel = 3'(s);
    cur_sel = s;
    @(negedge clk);
    chk("R10 link low after select change", link, 0);
  endtask

  task automatic pulse_clr();
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 reset link", link, 0);
    chk("R12 reset word_err", word_err, 0);
    chk("R12 reset word_count", word_count, 0);
    chk("R12 reset err_count", err_count, 0);
  endtask

  task automatic t_prbs7_lock();
    logic [DW-1:0] w, first;
    first = '0;
    for (int k = 1; k <= 6; k++) begin
      send_gen('0, w);
      if (k == 1) begin
        first = w;
        chk("R2 first word errored against empty window", word_err, 1);
      end else begin
        chk("R11 clean from second word", word_err, 0);
      end
      if (k == 5) chk("R3 no link after four clean words", link, 0);
    end
    chk("R3 link after five clean words", link, 1);
    chk("R6 word count", word_count, 6);
    chk("R7 bit errors of first word", err_count, 64'($countones(first)));
  endtask

  task automatic t_idle();
    repeat (5) @(negedge clk);
    chk("R6 idle cycles not counted", word_count, 6);
    chk("R2 flag held while idle", word_err, 0);
    chk("R5 idle keeps link", link, 1);
  endtask

  task automatic t_clear();
    pulse_clr();
    chk("R8 clear word_count", word_count, 0);
    chk("R8 clear err_count", err_count, 0);
    chk("R8 clear leaves link", link, 1);
  endtask

  task automatic t_freerun();
    logic [DW-1:0] w;
    send_gen(20'h80081, w);
    chk("R7 three bit errors", err_count, 3);
    chk("R2 flag on corrupted word", word_err, 1);
    chk("R5 single error keeps link", link, 1);
    send_gen('0, w);
    chk("R11 linked reference not disturbed", word_err, 0);
    chk("R7 no added errors", err_count, 3);
    chk("R6 two words", word_count, 2);
  endtask

  task automatic t_hysteresis();
    logic [DW-1:0] w;
    repeat (4) send_gen(20'h4, w);
    chk("R4 four errored words keep link", link, 1);
    send_gen('0, w);
    repeat (4) send_gen(20'h4, w);
    chk("R5 clean word restarts errored run", link, 1);
    send_gen(20'h4, w);
    chk("R4 link drops on fifth errored word", link, 0);
    chk("R7 accumulated bit errors", err_count, 12);
    for (int k = 1; k <= 5; k++) begin
      send_gen('0, w);
      if (k == 4) chk("R3 relock needs five", link, 0);
    end
    chk("R3 relock after five clean words", link, 1);
  endtask

  task automatic t_sel_runs();
    logic [DW-1:0] w;
    set_sel(1);
    set_sel(0);
    repeat (3) send_gen('0, w);
    chk("R11 aligned words clean", word_err, 0);
    set_sel(1);
    set_sel(0);
    repeat (4) send_gen('0, w);
    chk("R10 select change zeroed clean run", link, 0);
    send_gen('0, w);
    chk("R3 link after five clean since change", link, 1);
  endtask

  task automatic t_sync(input int s);
    logic [DW-1:0] w;
    int lim, errs;
    lim  = (s == 2 || s == 3) ? 7 : 6;
    bh   = 64'h9E37_79B9_7F4A_7C15 ^ (64'(s) << 40);
    set_sel(s);
    for (int k = 1; k <= lim; k++) begin
      send_gen('0, w);
      if (k == 4) chk($sformatf("R3 code %0d not linked early", s), link, 0);
    end
    chk($sformatf("R11 code %0d locked", s), link, 1);
    chk($sformatf("R1 code %0d clean at lock", s), word_err, 0);
    errs = 0;
    repeat (12) begin
      send_gen('0, w);
      if (word_err !== 1'b0 || link !== 1'b1) errs++;
    end
    chk($sformatf("R1 code %0d sustained", s), errs, 0);
  endtask

  task automatic t_clear_word();
    logic [DW-1:0] w;
    cnt_clr = 1'b1;
    send_gen(20'h1, w);
    cnt_clr = 1'b0;
    chk("R8 clear beats word count", word_count, 0);
    chk("R8 clear beats error count", err_count, 0);
    chk("R8 clear leaves link", link, 1);
  endtask

  task automatic s_send();
    s_rx    = '1;
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic t_saturate();
    repeat (4) s_send();
    chk("R7 ten errors per word", s_errs, 40);
    chk("R2 narrow instance flag", s_err, 1);
    repeat (2) s_send();
    chk("R7 sixty errors", s_errs, 60);
    s_send();
    chk("R9 error count saturates", s_errs, 63);
    repeat (8) s_send();
    chk("R9 word count reaches full", s_words, 15);
    s_send();
    chk("R9 word count saturates", s_words, 15);
    chk("R9 error count stays full", s_errs, 63);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_data = '0; rx_valid = 1'b0; pat_sel = 3'd0; cnt_clr = 1'b0;
    s_rx = '0; s_valid = 1'b0;
    bh = 64'h0123_4567_89AB_CDEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_prbs7_lock();
    t_idle();
    t_clear();
    t_freerun();
    t_hysteresis();
    t_sel_runs();
    t_sync(4);
    t_sync(5);
    t_sync(1);
    t_sync(2);
    t_sync(3);
    t_sync(6);
    t_clear_word();
    t_saturate();
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule